// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital front end of a two-channel 12-bit digital-to-analogue converter that is loaded over a three-wire serial link. The link has an active-low select, a serial clock and a data line. The block samples the three wires into its own system clock domain and shifts data in on each falling serial-clock edge while select is low, most significant bit first. Once exactly sixteen bits have arrived, the first rising edge of either the serial clock or the select line moves the word into the holding latch of one channel. A select that returns high early throws the partial word away.

Each 16-bit word has a channel bit in position 15, three unused control bits in positions 14 to 12 and a 12-bit code in positions 11 to 0. The two 12-bit latch outputs drive the converters. In analogue terms a code scales as code/4096 of twice the reference, so 2048 gives the reference level. A one-cycle update pulse per channel marks each latch write, which lets the order of updates be observed.

Top module: `sdac_frontend`

## Requirements
- R1: While and after synchronous reset (rst_n low), both latch outputs read zero and both update pulses are low.
- R2: While cs_n is low, each falling sclk edge shifts sdi into a 16-bit register. The first bit shifted lands in bit 15 of the word, so the word is sent most significant bit first.
- R3: Once 16 bits have been shifted, the next rising sclk edge transfers the word into a channel latch.
- R4: Once 16 bits have been shifted and no rising sclk edge has yet followed, a rising cs_n edge transfers the word.
- R5: At most one transfer occurs per word. Falling sclk edges after the 16th bit shift nothing, and later rising sclk or cs_n edges cause no further write.
- R6: While cs_n is high, sclk edges shift no data and change no latch.
- R7: If cs_n rises before 16 bits have arrived, the partial word is dropped and neither latch changes.
- R8: Word bit 15 selects the channel: 0 writes channel A and 1 writes channel B. Bits 11:0 are the code. Bits 14:12 have no effect.
- R9: Each latch write raises that channel's update pulse for exactly one clock. No pulse appears without a write, and the two pulses are never high together.
- R10: A falling cs_n edge restarts the bit count, so the bits of an earlier aborted word are not counted toward the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are oversampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (power-on clear) |
| cs_n | input | 1 | Serial select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data, sampled on falling sclk |
| code_a | output | 12 | Channel A latch value |
| code_b | output | 12 | Channel B latch value |
| upd_a | output | 1 | One-cycle pulse when channel A is written |
| upd_b | output | 1 | One-cycle pulse when channel B is written |

## Verification
Several properties are checked on every clock. The bit count never goes past sixteen, and a transfer fires only on a full count. No shift happens while the synchronised select is high. A latch output changes only in a cycle in which its own update pulse is high, and the pulses are single-cycle and never high together. Other behaviour shows only in the bench's scenarios, where a per-clock behavioural model is compared with the outputs: bit order, channel routing, the choice between the two transfer edges, dropping of short words, the restart of the count on a new select and the ignored control bits.

// File: rtl/sdac_pkg.sv
// Package: shared sizes and the serial word layout for the DAC front end.
// Assumes a 16-bit word with the channel bit at the top and the code at the bottom.
package sdac_pkg;
    localparam int WORD_W  = 16;
    localparam int CODE_W  = 12;
    localparam int NUM_CH  = 2;
    localparam int SYNC_N  = 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CTRL_W  = WORD_W - CODE_W;
endpackage

// File: rtl/sdac_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; every flop resets to RST_VAL so idle levels are seen at reset.
module sdac_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // First stage: capture the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stage: pass the sample one flop further.
        always_ff @(posedge clk) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
// Module: serial receiver with edge detection, shift register, saturating bit count
// and one-shot transfer request. Inputs must already be synchronised to clk.
// Assumes each serial level lasts at least two clk cycles.
module sdac_shift #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  cnt,
    output logic              xfer
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic cs_d, sclk_d, armed;
    logic cs_fall, cs_rise, sclk_fall, sclk_rise, full;

    // Edge decode against the previous synchronised level.
    always_comb begin
        cs_fall   = cs_d & ~cs_n;
        cs_rise   = ~cs_d & cs_n;
        sclk_fall = sclk_d & ~sclk;
        sclk_rise = ~sclk_d & sclk;
        full      = (cnt == FULL);
        xfer      = armed & full & ~cs_fall & (sclk_rise | cs_rise);
    end

    // Previous-level registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_n;
            sclk_d <= sclk;
        end
    end

    // Word state: restart on select, disarm on transfer or abort, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            cnt   <= '0;
            armed <= 1'b0;
        end else if (cs_fall) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (xfer || cs_rise) begin
            armed <= 1'b0;
        end else if (sclk_fall && !cs_n && !full) begin
            word <= {word[WORD_W-2:0], sdi};
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdac_latch_bank.sv
// Module: per-channel holding latches with one-cycle update pulses.
// Assumes the channel index sits in the top word bits and the code in the bottom.
module sdac_latch_bank #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 12,
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xfer,
    input  logic [WORD_W-1:0]             word,
    output logic [NUM_CH-1:0][CODE_W-1:0] code,
    output logic [NUM_CH-1:0]             upd
);
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] val;
    logic [WORD_W-SEL_W-CODE_W-1:0] unused_ctrl;

    // Field split of the received word.
    always_comb begin
        sel         = word[WORD_W-1 -: SEL_W];
        val         = word[CODE_W-1:0];
        unused_ctrl = word[WORD_W-SEL_W-1:CODE_W];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Channel latch: load on a transfer addressed to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code[c] <= '0;
                upd[c]  <= 1'b0;
            end else begin
                upd[c] <= xfer && (sel == SEL_W'(c));
                if (xfer && (sel == SEL_W'(c))) code[c] <= val;
            end
        end
    end
endmodule

// File: rtl/sdac_frontend.sv
// Module: top of the serial-load DAC input register. Synchronises the three serial
// wires, receives 16-bit words and routes each complete word to a channel latch.
// Assumes serial levels are held for at least two clk cycles each.
module sdac_frontend
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd_a,
    output logic              upd_b
);
    logic [2:0]                    sync_q;
    logic                          cs_s, sclk_s, sdi_s;
    logic [WORD_W-1:0]             rx_word;
    logic [CNT_W-1:0]              rx_cnt;
    logic                          rx_xfer;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_code;
    logic [NUM_CH-1:0]             ch_upd;

    sdac_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(sync_q)
    );

    // Unpack the synchronised bundle.
    always_comb begin
        cs_s   = sync_q[2];
        sclk_s = sync_q[1];
        sdi_s  = sync_q[0];
    end

    sdac_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .sclk(sclk_s), .sdi(sdi_s),
        .word(rx_word), .cnt(rx_cnt), .xfer(rx_xfer)
    );

    sdac_latch_bank #(.WORD_W(WORD_W), .CODE_W(CODE_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .xfer(rx_xfer), .word(rx_word),
        .code(ch_code), .upd(ch_upd)
    );

    // Present the two channels at the ports.
    always_comb begin
        code_a = ch_code[0];
        code_b = ch_code[1];
        upd_a  = ch_upd[0];
        upd_b  = ch_upd[1];
    end
endmodule

// File: rtl/sdac_frontend_chk.sv
// Module: property checker for sdac_frontend, attached by bind.
module sdac_frontend_chk #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 12,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic [WORD_W-1:0] rx_word,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              rx_xfer,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic              upd_a,
    input logic              upd_b
);
    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(WORD_W));
    // R3
    xfer_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_xfer |-> (rx_cnt == CNT_W'(WORD_W)));
    // R6
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable(rx_word));
    // R9
    upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_a && upd_b));
    // R9
    latch_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a != $past(code_a)) |-> upd_a);
    // R9
    latch_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_b != $past(code_b)) |-> upd_b);
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_a || upd_b) |=> !(upd_a || upd_b));
endmodule

bind sdac_frontend sdac_frontend_chk #(
    .WORD_W(sdac_pkg::WORD_W), .CODE_W(sdac_pkg::CODE_W), .CNT_W(sdac_pkg::CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rx_word(rx_word), .rx_cnt(rx_cnt),
    .rx_xfer(rx_xfer), .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b)
);

// File: tb/sdac_frontend_test.sv
module sdac_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [11:0] code_a, code_b;
    logic upd_a, upd_b;

    int checks = 0, errors = 0;
    int cnt_ua = 0, cnt_ub = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_frontend uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference: event-level model on the raw pins, output delayed two clocks.
    int          m_cnt = 0;
    bit          m_armed = 0;
    logic [15:0] m_sr = '0;
    logic [11:0] m_a = '0, m_b = '0;
    bit          m_ua, m_ub;
    logic        p_cs = 1'b1, p_sclk = 1'b0;
    logic [25:0] hist [3] = '{default: '0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_armed = 0; m_sr = '0; m_a = '0; m_b = '0;
            p_cs = 1'b1; p_sclk = 1'b0;
            hist[0] = '0; hist[1] = '0; hist[2] = '0;
        end else begin
            m_ua = 0; m_ub = 0;
            if (p_cs && !cs_n) begin
                m_cnt = 0; m_armed = 1;
            end else if (m_armed && m_cnt == 16 && ((!p_sclk && sclk) || (!p_cs && cs_n))) begin
                if (m_sr[15]) begin m_b = m_sr[11:0]; m_ub = 1; end
                else          begin m_a = m_sr[11:0]; m_ua = 1; end
                m_armed = 0;
            end else if (!p_cs && cs_n) begin
                m_armed = 0;
            end else if (p_sclk && !sclk && !cs_n && m_cnt < 16) begin
                m_sr = {m_sr[14:0], sdi};
                m_cnt++;
            end
            p_cs = cs_n; p_sclk = sclk;
            hist[2] = hist[1]; hist[1] = hist[0];
            hist[0] = {m_ub, m_ua, m_b, m_a};
        end
    end

    // Per-clock comparison and pulse counting, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 latch A vs model", {20'd0, code_a}, {20'd0, hist[2][11:0]});
            chk("R8 latch B vs model", {20'd0, code_b}, {20'd0, hist[2][23:12]});
            chk("R9 pulses vs model", {30'd0, upd_b, upd_a}, {30'd0, hist[2][25:24]});
            if (upd_a) cnt_ua++;
            if (upd_b) cnt_ub++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) begin
            sdi = w[i]; sclk = 1'b1; wait_clk(HB);
            sclk = 1'b0; wait_clk(HB);
        end
    endtask

    // Full word; via_sclk picks the rising-sclk transfer, else the cs_n rise.
    task automatic send_word(input logic [15:0] w, input bit via_sclk);
        cs_n = 1'b0; wait_clk(HB);
        shift_bits(w, 16);
        if (via_sclk) begin
            sclk = 1'b1; wait_clk(HB); sclk = 1'b0; wait_clk(HB);
        end
        cs_n = 1'b1; wait_clk(4 * HB);
    endtask

    initial begin
        int a0, b0;
        wait_clk(5);
        // R1: reset state
        chk("R1 code_a at reset", {20'd0, code_a}, 32'd0);
        chk("R1 code_b at reset", {20'd0, code_b}, 32'd0);
        chk("R1 pulses at reset", {30'd0, upd_b, upd_a}, 32'd0);
        rst_n = 1'b1; wait_clk(4);
        chk("R1 code_a after reset", {20'd0, code_a}, 32'd0);

        // R2 R3: MSB-first word to channel A via rising sclk
        a0 = cnt_ua;
        send_word(16'h0ABC, 1);
        chk("R3 code_a after sclk transfer", {20'd0, code_a}, 32'h0ABC);
        chk("R9 one pulse on A", a0 + 1, cnt_ua);
        send_word(16'h0801, 1);
        chk("R2 bit order", {20'd0, code_a}, 32'h0801);

        // R4 R8: channel B via cs_n rise
        b0 = cnt_ub;
        send_word(16'h8123, 0);
        chk("R4 code_b after cs transfer", {20'd0, code_b}, 32'h0123);
        chk("R8 code_a untouched", {20'd0, code_a}, 32'h0801);
        chk("R9 one pulse on B", b0 + 1, cnt_ub);

        // R8: bits 14:12 have no effect
        send_word(16'hF555, 0);
        chk("R8 control bits ignored", {20'd0, code_b}, 32'h0555);
        send_word(16'h7321, 0);
        chk("R8 control bits ignored A", {20'd0, code_a}, 32'h0321);

        // R5: extra edges after the transfer
        a0 = cnt_ua;
        cs_n = 1'b0; wait_clk(HB);
        shift_bits(16'h0246, 16);
        shift_bits(16'hFFFF, 5);
        cs_n = 1'b1; wait_clk(4 * HB);
        chk("R5 single transfer", a0 + 1, cnt_ua);
        chk("R5 first word kept", {20'd0, code_a}, 32'h0246);

        // R7: short word dropped
        a0 = cnt_ua; b0 = cnt_ub;
        cs_n = 1'b0; wait_clk(HB);
        shift_bits(16'h0FFF, 10);
        cs_n = 1'b1; wait_clk(4 * HB);
        chk("R7 no pulse on short word", a0 + b0, cnt_ua + cnt_ub);
        chk("R7 code_a unchanged", {20'd0, code_a}, 32'h0246);

        // R6: sclk toggles with cs_n high
        shift_bits(16'h8FFF, 16);
        wait_clk(4 * HB);
        chk("R6 no pulse with cs high", a0 + b0, cnt_ua + cnt_ub);
        chk("R6 code_b unchanged", {20'd0, code_b}, 32'h0555);

        // R10: aborted bits do not count toward the next word
        cs_n = 1'b0; wait_clk(HB);
        shift_bits(16'hFFFF, 5);
        cs_n = 1'b1; wait_clk(2 * HB);
        send_word(16'h0777, 1);
        chk("R10 count restarted", {20'd0, code_a}, 32'h0777);
        chk("R10 single pulse", a0 + 1, cnt_ua);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule